// File: doc/BRIEF.md
# Block Memory Compare Step

This unit performs one step of a buffer scan. It holds a 16-bit address pointer and a 16-bit byte counter. One command reads the byte at the pointer through a synchronous memory read port and compares it with an 8-bit accumulator value. The command then stores the equality result in a flag, adds one to the pointer and subtracts one from the counter. A second flag reports whether the counter is still nonzero after the step, so software can scan a buffer one step at a time and do other work between steps.

Software loads the pointer and the counter while the unit is idle, then pulses `start` with the accumulator value on `acc_in`. Each step takes a fixed two cycles: a read cycle and then an update cycle. `step_done` is high during the update cycle. The new register and flag values are visible from the cycle after that.

Top module: `cmpstep_unit`

## Requirements
- R1: After reset, `ptr_q`, `cnt_q`, `eq_flag`, `nz_flag`, `step_done` and `busy` are all 0.
- R2: When `busy` is 0 and `start` is 0, a cycle with `load` high sets `ptr_q` to `ptr_in` and `cnt_q` to `cnt_in` from the next cycle. `load` is ignored while `busy` is 1 or `start` is high, and it leaves both flags unchanged.
- R3: `start` while idle gives exactly this sequence: on the next cycle `mem_rd_en` is 1 with `mem_addr` equal to `ptr_q`, on the cycle after that `step_done` is 1, and then the unit is idle again. `busy` is 1 on both of those cycles. `start` while `busy` is 1 is ignored.
- R4: At the end of the update cycle, `eq_flag` becomes 1 if the accumulator value equals the byte returned on `mem_rdata` in the update cycle, and 0 otherwise.
- R5: At the end of the update cycle, `ptr_q` becomes `ptr_q + 1` modulo 2^16, so 16'hFFFF goes to 16'h0000.
- R6: At the end of the update cycle, `cnt_q` becomes `cnt_q - 1` modulo 2^16, so 16'h0000 goes to 16'hFFFF.
- R7: At the end of the update cycle, `nz_flag` becomes 1 exactly when the decremented counter is not zero.
- R8: The compare uses the value of `acc_in` captured in the `start` cycle. Later changes on `acc_in` during the step have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load pointer and counter when idle |
| ptr_in | input | 16 | Pointer value to load |
| cnt_in | input | 16 | Counter value to load |
| start | input | 1 | Begin one compare step |
| acc_in | input | 8 | Accumulator value to compare |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| busy | output | 1 | Step in progress |
| step_done | output | 1 | High during the update cycle |
| ptr_q | output | 16 | Current pointer |
| cnt_q | output | 16 | Current counter |
| eq_flag | output | 1 | Last compare was equal |
| nz_flag | output | 1 | Counter nonzero after last step |

## Verification
The bench steps the pointer across 16'hFFFF and the counter through 16'h0001 and 16'h0000. A design that gets these wrong would saturate instead of wrapping, or would report the counter as nonzero at the last byte. Accumulator values are forced both to match and to miss the memory byte, and `acc_in` is scrambled during the read cycle. A unit that compares a live or stale operand would set the equality flag wrongly. The bench also sends `start` and `load` in the middle of a step, which a design without proper guards would let restart the step or corrupt the registers.

// File: rtl/cmpstep_pkg.sv
package cmpstep_pkg;
  localparam int PTR_W  = 16;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_UPD  = 2'd2
  } step_state_t;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic bytes_equal(input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] b);
    return a == b;
  endfunction
endpackage

// File: rtl/cmpstep_seq.sv
module cmpstep_seq
  import cmpstep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic step_go,
  output logic rd_phase,
  output logic upd_phase
);
  step_state_t state_q, state_d;

  assign step_go   = (state_q == ST_IDLE) && start;
  assign rd_phase  = (state_q == ST_READ);
  assign upd_phase = (state_q == ST_UPD);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_READ;
      ST_READ: state_d = ST_UPD;
      ST_UPD:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/cmpstep_regs.sv
module cmpstep_regs
  import cmpstep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_fire,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              step_go,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              upd_fire,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              eq_q,
  output logic              nz_q
);
  logic [DATA_W-1:0] acc_hold;
  logic [CNT_W-1:0]  cnt_dec;

  assign cnt_dec = next_cnt(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_hold <= '0;
    end else if (step_go) begin
      acc_hold <= acc_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
      eq_q  <= 1'b0;
      nz_q  <= 1'b0;
    end else if (upd_fire) begin
      ptr_q <= next_ptr(ptr_q);
      cnt_q <= cnt_dec;
      eq_q  <= bytes_equal(acc_hold, mem_rdata);
      nz_q  <= (cnt_dec != '0);
    end else if (ld_fire) begin
      ptr_q <= ptr_in;
      cnt_q <= cnt_in;
    end
  end
endmodule

// File: rtl/cmpstep_unit.sv
module cmpstep_unit
  import cmpstep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              start,
  input  logic [DATA_W-1:0] acc_in,
  output logic              mem_rd_en,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              step_done,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              eq_flag,
  output logic              nz_flag
);
  logic step_go, rd_phase, upd_phase, ld_fire;

  cmpstep_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step_go   (step_go),
    .rd_phase  (rd_phase),
    .upd_phase (upd_phase)
  );

  assign busy    = rd_phase | upd_phase;
  assign ld_fire = load & ~busy & ~start;

  cmpstep_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_fire   (ld_fire),
    .ptr_in    (ptr_in),
    .cnt_in    (cnt_in),
    .step_go   (step_go),
    .acc_in    (acc_in),
    .upd_fire  (upd_phase),
    .mem_rdata (mem_rdata),
    .ptr_q     (ptr_q),
    .cnt_q     (cnt_q),
    .eq_q      (eq_flag),
    .nz_q      (nz_flag)
  );

  assign mem_rd_en = rd_phase;
  assign mem_addr  = ptr_q;
  assign step_done = upd_phase;
endmodule

// File: rtl/cmpstep_chk.sv
module cmpstep_chk
  import cmpstep_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             step_go,
  input logic             ld_fire,
  input logic             mem_rd_en,
  input logic             step_done,
  input logic             busy,
  input logic [PTR_W-1:0] ptr_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             nz_flag
);
  a_r3_read_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
    step_go |=> mem_rd_en);
  a_r3_done_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> step_done);
  a_r3_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_en, step_done}));
  a_r3_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !busy);
  a_r5_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> ptr_q == $past(ptr_q) + 16'd1);
  a_r6_cnt_retreat: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> cnt_q == $past(cnt_q) - 16'd1);
  a_r7_nz_matches: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> nz_flag == (cnt_q != 16'd0));
  a_r2_regs_hold_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> ($stable(ptr_q) && $stable(cnt_q)));
  a_r2_no_load_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_fire);
endmodule

bind cmpstep_unit cmpstep_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_go   (step_go),
  .ld_fire   (ld_fire),
  .mem_rd_en (mem_rd_en),
  .step_done (step_done),
  .busy      (busy),
  .ptr_q     (ptr_q),
  .cnt_q     (cnt_q),
  .nz_flag   (nz_flag)
);

// File: tb/cmpstep_unit_test.sv
module cmpstep_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [15:0] ptr_in = '0;
  logic [15:0] cnt_in = '0;
  logic        start = 1'b0;
  logic [7:0]  acc_in = '0;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        busy, step_done, eq_flag, nz_flag;
  logic [15:0] ptr_q, cnt_q;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int seed_dummy;

  always #4 clk = ~clk;

  cmpstep_unit uut (
    .clk(clk), .rst_n(rst_n), .load(load), .ptr_in(ptr_in), .cnt_in(cnt_in),
    .start(start), .acc_in(acc_in), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .busy(busy), .step_done(step_done), .ptr_q(ptr_q),
    .cnt_q(cnt_q), .eq_flag(eq_flag), .nz_flag(nz_flag)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem_byte(mem_addr);
  end

  function automatic logic [15:0] exp_up(input logic [15:0] v);
    logic [16:0] w = {1'b0, v} + 17'd1;
    return w[15:0];
  endfunction

  function automatic logic [15:0] exp_down(input logic [15:0] v);
    return (v == 16'h0000) ? 16'hFFFF : v + 16'hFFFF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] p, input logic [15:0] c);
    @(negedge clk);
    load = 1'b1; ptr_in = p; cnt_in = c;
    @(negedge clk);
    load = 1'b0;
    check("R2 load ptr", ptr_q, p);
    check("R2 load cnt", cnt_q, c);
  endtask

  // One step with full expected-value checking; disturb scrambles inputs mid-step
  task automatic do_step(input logic [7:0] acc, input bit disturb);
    logic [15:0] p0, c0;
    logic        ef0, nf0;
    p0 = ptr_q; c0 = cnt_q; ef0 = eq_flag; nf0 = nz_flag;
    @(negedge clk);
    start = 1'b1; acc_in = acc;
    @(negedge clk);
    start = disturb; load = disturb;
    ptr_in = 16'hDEAD; cnt_in = 16'hBEEF;
    if (disturb) acc_in = ~acc;
    check("R3 read strobe", {31'd0, mem_rd_en}, 32'd1);
    check("R3 read addr", mem_addr, p0);
    check("R3 busy in read", {31'd0, busy}, 32'd1);
    check("R3 no done in read", {31'd0, step_done}, 32'd0);
    @(negedge clk);
    check("R3 done pulse", {31'd0, step_done}, 32'd1);
    check("R3 busy in update", {31'd0, busy}, 32'd1);
    check("R2 regs held mid-step", {ptr_q, cnt_q}, {p0, c0});
    check("R4 flags held mid-step", {30'd0, eq_flag, nz_flag}, {30'd0, ef0, nf0});
    start = 1'b0; load = 1'b0;
    @(negedge clk);
    check("R3 idle after step", {30'd0, busy, step_done}, 32'd0);
    check("R5 ptr advance", ptr_q, exp_up(p0));
    check("R6 cnt retreat", cnt_q, exp_down(c0));
    check("R7 nz flag", {31'd0, nz_flag}, {31'd0, exp_down(c0) != 16'd0});
    check(disturb ? "R8 captured acc compare" : "R4 eq flag", {31'd0, eq_flag},
          {31'd0, acc == mem_byte(p0)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset regs", {ptr_q, cnt_q}, 32'd0);
    check("R1 reset flags", {28'd0, eq_flag, nz_flag, step_done, busy}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {31'd0, mem_rd_en}, 32'd0);

    // R5 pointer wrap, R4 equal match
    do_load(16'hFFFF, 16'h0003);
    do_step(mem_byte(16'hFFFF), 1'b0);
    check("R5 wrap to zero", ptr_q, 16'h0000);
    // R4 mismatch
    do_step(mem_byte(16'h0000) ^ 8'h01, 1'b0);
    check("R4 miss clears eq", {31'd0, eq_flag}, 32'd0);
    // R7 counter reaches zero
    do_step(8'h00, 1'b0);
    check("R7 last byte", {cnt_q, 15'd0, nz_flag}, 32'd0);
    // R6 counter wrap from zero
    do_step(8'h00, 1'b0);
    check("R6 wrap to FFFF", cnt_q, 16'hFFFF);

    // R8 acc scrambled mid-step, equal case
    do_load(16'h1234, 16'h0010);
    do_step(mem_byte(16'h1234), 1'b1);
    check("R8 equal despite change", {31'd0, eq_flag}, 32'd1);

    // R2 load together with start is ignored
    @(negedge clk);
    load = 1'b1; start = 1'b1; ptr_in = 16'h0F0F; cnt_in = 16'h0F0F; acc_in = 8'h00;
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    check("R2 load with start ignored", ptr_q, 16'h1235);
    @(negedge clk); @(negedge clk);
    check("R2 step ran instead", ptr_q, 16'h1236);

    // R2 load does not touch flags
    begin
      logic ef, nf;
      ef = eq_flag; nf = nz_flag;
      do_load(16'h0100, 16'h0001);
      check("R2 flags kept on load", {30'd0, eq_flag, nf}, {30'd0, ef, nz_flag});
    end

    // random stimulus with fixed seed
    seed_dummy = $urandom(32'd7);
    for (int i = 0; i < 200; i++) begin
      logic [15:0] rp;
      if ($urandom_range(0, 7) == 0) do_load(16'($urandom), 16'($urandom_range(0, 3)));
      rp = ptr_q;
      do_step(($urandom_range(0, 1) == 1) ? mem_byte(rp) : 8'($urandom), 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule